// File: doc/BRIEF.md
# DMA Address and Byte-Lane Formatter

This block produces the address and the lane-steered data for each beat of a DMA transfer on a 16-bit address/data bus. Software first writes a small configuration register. Its three bits choose byte or word transfers, the byte order used in word mode, and whether the upper half of a 32-bit address is driven from a second start register (long mode) or held at zero (dual 16-bit mode). A load then supplies a lower start address, an upper start address and a byte count.

While a transfer is active, each data beat arriving on the input stream passes through to the output stream. The beat leaves with the current address and with its bytes placed on the proper lanes. The lower address then steps by one byte or one word, and the count drops by the same amount. When the count reaches zero the block goes idle and raises `done`.

The input stream (`in_valid`/`in_ready`) and the output stream (`bus_valid`/`bus_ready`) use valid/ready rules with no buffering in between. `in_ready` follows `bus_ready`, and `bus_valid` follows `in_valid`, but only while a transfer is active and no load is being presented. A beat moves only in a cycle where `in_valid` and `in_ready` are both high. A sink may hold `bus_ready` low for any number of cycles. During that time the address, count and data do not move, and `in_data` must be held.

Top module: `dma_lane_formatter`

## Requirements
- R1: After reset `busy`, `done`, `in_ready` and `bus_valid` are 0, and the configuration is byte mode, no swap, long mode (long select resets to 1).
- R2: In byte mode (word bit 0) each beat is driven as `bus_data = {8'h00, in_data[7:0]}`, and the lower address starts at the loaded value and rises by 1 per beat.
- R3: In word mode (word bit 1) bit 0 of `bus_addr` is always 0, and the lower address rises by 2 per beat.
- R4: In word mode with swap bit 0, `bus_data = in_data`, so the most significant byte sits on bits 15..8. With swap bit 1, `bus_data = {in_data[7:0], in_data[15:8]}`.
- R5: The swap bit has no effect on the data in byte mode.
- R6: In long mode `bus_addr[31:16]` equals the loaded upper start address. In dual mode `bus_addr[31:16]` is 0. `bus_addr[15:0]` is always the lower address, wrapping modulo 2^16.
- R7: The count falls by the step (1 or 2) on each beat and saturates at 0. On the beat that takes it to 0, `busy` falls and `done` rises on the next clock. `done` and `busy` are never high together.
- R8: The configuration is captured at load. A write to the configuration register during an active transfer does not change that transfer's addresses or data.
- R9: `in_ready = bus_ready` and `bus_valid = in_valid` while busy and no load is presented. Both are 0 while idle. Address and count hold during a stalled cycle.
- R10: A load presented in the same cycle as a waiting beat wins. `in_ready` is 0 in that cycle, no beat moves, and the new transfer starts from its own start address.
- R11: A load with count 0 leaves `busy` at 0 and sets `done` at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_wr | input | 1 | Write strobe for the configuration register |
| cfg_word | input | 1 | 1 = word transfers, 0 = byte transfers |
| cfg_swap | input | 1 | 1 = swap byte lanes in word mode |
| cfg_long | input | 1 | 1 = drive upper address from upper start |
| ld_valid | input | 1 | Load a new transfer |
| ld_start_lo | input | 16 | Lower start address |
| ld_start_hi | input | 16 | Upper start address (long mode) |
| ld_count | input | 16 | Transfer length in bytes |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted |
| in_data | input | 16 | Input beat, most significant byte in bits 15..8 |
| bus_valid | output | 1 | Output beat valid |
| bus_ready | input | 1 | Output sink ready |
| bus_addr | output | 32 | Address of the current beat |
| bus_data | output | 16 | Lane-steered data |
| busy | output | 1 | Transfer active |
| done | output | 1 | Last transfer finished |

## Verification
A new load and a data beat can fall in the same cycle. So can a configuration write and a transfer that is still active. The bench presents a waiting beat during every load cycle. It then checks that `in_ready` is low and that the first beat afterwards carries the new start address. After the first beat of every run it writes the inverted configuration and judges each later beat against the configuration captured at load. A sweep over all eight configuration combinations, odd, even and wrapping start addresses, and odd and even counts checks the address, lane placement and beat count, with a stall every third cycle.

// File: rtl/dlf_pkg.sv
package dlf_pkg;
  typedef struct packed {
    logic long_addr;
    logic swap;
    logic word;
  } dlf_cfg_t;

  localparam dlf_cfg_t CFG_RESET = '{long_addr: 1'b1, swap: 1'b0, word: 1'b0};
endpackage

// File: rtl/dlf_cfg_reg.sv
module dlf_cfg_reg
  import dlf_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr,
  input  dlf_cfg_t din,
  output dlf_cfg_t q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= CFG_RESET;
    else if (wr) q <= din;
  end
endmodule

// File: rtl/dlf_addr_seq.sv
module dlf_addr_seq
  import dlf_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [AW-1:0] ld_lo,
  input  logic [AW-1:0] ld_hi,
  input  logic [CW-1:0] ld_cnt,
  input  dlf_cfg_t      ld_cfg,
  input  logic          adv,
  output logic          busy,
  output logic          done,
  output dlf_cfg_t      act_cfg,
  output logic [AW-1:0] lo_q,
  output logic [AW-1:0] hi_q,
  output logic [CW-1:0] cnt_q
);
  logic [CW-1:0] step_c;
  logic [AW-1:0] step_a;

  assign step_c = act_cfg.word ? CW'(2) : CW'(1);
  assign step_a = act_cfg.word ? AW'(2) : AW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      act_cfg <= CFG_RESET;
      lo_q    <= '0;
      hi_q    <= '0;
      cnt_q   <= '0;
    end else if (ld) begin
      busy    <= (ld_cnt != '0);
      done    <= (ld_cnt == '0);
      act_cfg <= ld_cfg;
      lo_q    <= ld_lo;
      hi_q    <= ld_hi;
      cnt_q   <= ld_cnt;
    end else if (adv) begin
      lo_q <= lo_q + step_a;
      if (cnt_q <= step_c) begin
        cnt_q <= '0;
        busy  <= 1'b0;
        done  <= 1'b1;
      end else begin
        cnt_q <= cnt_q - step_c;
      end
    end
  end
endmodule

// File: rtl/dlf_lane_steer.sv
module dlf_lane_steer #(
  parameter int LW = 8
) (
  input  logic          word,
  input  logic          swap,
  input  logic [2*LW-1:0] din,
  output logic [2*LW-1:0] dout
);
  localparam int NL = 2;

  for (genvar g = 0; g < NL; g++) begin : g_lane
    localparam int OTHER = NL - 1 - g;
    always_comb begin
      if (!word)     dout[g*LW +: LW] = (g == 0) ? din[LW-1:0] : '0;
      else if (swap) dout[g*LW +: LW] = din[OTHER*LW +: LW];
      else           dout[g*LW +: LW] = din[g*LW +: LW];
    end
  end
endmodule

// File: rtl/dma_lane_formatter.sv
module dma_lane_formatter
  import dlf_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int LW = 8,
  localparam int DW = 2 * LW,
  localparam int FW = 2 * AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic          cfg_word,
  input  logic          cfg_swap,
  input  logic          cfg_long,
  input  logic          ld_valid,
  input  logic [AW-1:0] ld_start_lo,
  input  logic [AW-1:0] ld_start_hi,
  input  logic [CW-1:0] ld_count,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          bus_valid,
  input  logic          bus_ready,
  output logic [FW-1:0] bus_addr,
  output logic [DW-1:0] bus_data,
  output logic          busy,
  output logic          done
);
  dlf_cfg_t      cfg_q;
  dlf_cfg_t      cfg_in;
  dlf_cfg_t      act_cfg;
  logic [AW-1:0] lo_q;
  logic [AW-1:0] hi_q;
  logic [CW-1:0] cnt_q;
  logic          hs;

  assign cfg_in = '{long_addr: cfg_long, swap: cfg_swap, word: cfg_word};

  dlf_cfg_reg i_cfg (
    .clk (clk),
    .rst_n (rst_n),
    .wr  (cfg_wr),
    .din (cfg_in),
    .q   (cfg_q)
  );

  assign in_ready  = busy & bus_ready & ~ld_valid;
  assign bus_valid = busy & in_valid & ~ld_valid;
  assign hs        = in_valid & in_ready;

  dlf_addr_seq #(.AW(AW), .CW(CW)) i_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld      (ld_valid),
    .ld_lo   (ld_start_lo),
    .ld_hi   (ld_start_hi),
    .ld_cnt  (ld_count),
    .ld_cfg  (cfg_q),
    .adv     (hs),
    .busy    (busy),
    .done    (done),
    .act_cfg (act_cfg),
    .lo_q    (lo_q),
    .hi_q    (hi_q),
    .cnt_q   (cnt_q)
  );

  assign bus_addr = {act_cfg.long_addr ? hi_q : '0,
                     lo_q[AW-1:1], lo_q[0] & ~act_cfg.word};

  dlf_lane_steer #(.LW(LW)) i_steer (
    .word (act_cfg.word),
    .swap (act_cfg.swap),
    .din  (in_data),
    .dout (bus_data)
  );
endmodule

// File: rtl/dlf_checker.sv
module dlf_checker
  import dlf_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        ld_valid,
  input logic        in_ready,
  input logic        bus_valid,
  input logic [31:0] bus_addr,
  input logic [15:0] bus_data,
  input logic        busy,
  input logic        done,
  input logic        hs,
  input dlf_cfg_t    act_cfg,
  input logic [15:0] cnt_q
);
  AST_IDLE_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!in_ready && !bus_valid)); // R9
  AST_WORD_A0_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && act_cfg.word) |-> (bus_addr[0] == 1'b0)); // R3
  AST_DUAL_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !act_cfg.long_addr) |-> (bus_addr[31:16] == 16'h0)); // R6
  AST_BYTE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !act_cfg.word) |-> (bus_data[15:8] == 8'h0)); // R2
  AST_DONE_EXCL_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && busy)); // R7
  AST_LOAD_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> !in_ready); // R10
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && (cnt_q > (act_cfg.word ? 16'd2 : 16'd1))) |=>
      (bus_addr[15:0] == 16'($past(bus_addr[15:0]) + ($past(act_cfg.word) ? 16'd2 : 16'd1)))); // R2
  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ld_valid) |=> $stable(act_cfg)); // R8
endmodule

bind dma_lane_formatter dlf_checker i_chk (.*);

// File: tb/test_dma_lane_formatter.sv
module test_dma_lane_formatter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0, cfg_word = 1'b0, cfg_swap = 1'b0, cfg_long = 1'b0;
  logic        ld_valid = 1'b0;
  logic [15:0] ld_start_lo = '0, ld_start_hi = '0, ld_count = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_data = '0;
  logic        bus_valid;
  logic        bus_ready = 1'b0;
  logic [31:0] bus_addr;
  logic [15:0] bus_data;
  logic        busy, done;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  dma_lane_formatter i_dma_lane_formatter (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_cfg(input bit w, input bit s, input bit l);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_word = w; cfg_swap = s; cfg_long = l;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  // Load with a beat waiting at the input (R10)
  task automatic do_load(input logic [15:0] lo, input logic [15:0] hi, input logic [15:0] cnt);
    @(negedge clk);
    ld_valid = 1'b1; ld_start_lo = lo; ld_start_hi = hi; ld_count = cnt;
    in_valid = 1'b1; bus_ready = 1'b1; in_data = 16'hDEAD;
    #1;
    chk(in_ready == 1'b0, "R10", 32'(in_ready), 32'h0);
    @(negedge clk);
    ld_valid = 1'b0; in_valid = 1'b0;
  endtask

  task automatic run(input bit w, input bit s, input bit l,
                     input logic [15:0] lo, input logic [15:0] hi, input logic [15:0] cnt);
    logic [15:0] elo, ecnt, d, ed, step;
    logic [31:0] ea;
    int k = 0;
    set_cfg(w, s, l);
    do_load(lo, hi, cnt);
    elo = lo; ecnt = cnt; step = w ? 16'd2 : 16'd1;
    while (ecnt != 0 && k < 100) begin
      bit stall = (k % 3 == 2);
      @(negedge clk);
      d = {8'(k * 37 + 5 + lo), 8'(k * 11 + 3 + cnt)};
      in_valid = 1'b1; bus_ready = !stall; in_data = d;
      #1;
      chk(bus_valid == 1'b1, "R9", 32'(bus_valid), 32'h1);
      chk(in_ready == !stall, "R9", 32'(in_ready), 32'(!stall));
      ea = {l ? hi : 16'h0, elo[15:1], elo[0] & ~w};
      chk(bus_addr == ea, w ? "R3" : "R2", bus_addr, ea);
      chk(bus_addr[31:16] == ea[31:16], "R6", 32'(bus_addr[31:16]), 32'(ea[31:16]));
      if (!w) ed = {8'h00, d[7:0]};
      else if (s) ed = {d[7:0], d[15:8]};
      else ed = d;
      chk(bus_data == ed, w ? "R4" : "R5", 32'(bus_data), 32'(ed));
      @(posedge clk);
      if (!stall) begin
        elo = elo + step;
        ecnt = (ecnt <= step) ? 16'h0 : ecnt - step;
        if (k == 0 && ecnt != 0) begin
          @(negedge clk);
          in_valid = 1'b0;
          cfg_wr = 1'b1; cfg_word = !w; cfg_swap = !s; cfg_long = !l; // R8
          @(negedge clk);
          cfg_wr = 1'b0;
        end
      end
      k++;
    end
    @(negedge clk);
    in_valid = 1'b0;
    #1;
    chk(busy == 1'b0, "R7", 32'(busy), 32'h0);
    chk(done == 1'b1, "R7", 32'(done), 32'h1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] starts[4];
    logic [15:0] counts[3];
    starts = '{16'h0000, 16'h0001, 16'hFFFE, 16'h7FFF};
    counts = '{16'd1, 16'd2, 16'd5};
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(busy == 1'b0, "R1", 32'(busy), 32'h0);
    chk(done == 1'b0, "R1", 32'(done), 32'h0);
    chk(in_ready == 1'b0, "R1", 32'(in_ready), 32'h0);
    rst_n = 1'b1;
    // R1: reset configuration is byte, no swap, long
    do_load(16'h1235, 16'hABCD, 16'd3);
    @(negedge clk);
    in_valid = 1'b1; bus_ready = 1'b1; in_data = 16'h9A5C;
    #1;
    chk(bus_addr == 32'hABCD1235, "R1", bus_addr, 32'hABCD1235);
    chk(bus_data == 16'h005C, "R1", 32'(bus_data), 32'h005C);
    @(negedge clk);
    in_valid = 1'b0;
    // R11: count zero
    do_load(16'h0040, 16'h0001, 16'd0);
    #1;
    chk(busy == 1'b0, "R11", 32'(busy), 32'h0);
    chk(done == 1'b1, "R11", 32'(done), 32'h1);
    in_valid = 1'b1; bus_ready = 1'b1;
    #1;
    chk(bus_valid == 1'b0, "R11", 32'(bus_valid), 32'h0);
    in_valid = 1'b0;
    for (int c = 0; c < 8; c++)
      for (int a = 0; a < 4; a++)
        for (int n = 0; n < 3; n++)
          run(c[0], c[1], c[2], starts[a], 16'(16'h1000 * a + c + 1), counts[n]);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule